// File: doc/BRIEF.md
# Hierarchical Best-Bin Page Color Selector

This block picks a cache bin (a page color) for the next physical page that an allocator hands to the running address space. The aim is fewer cache conflicts. Each bin has two counters. One counts the pages already given to the current address space in that bin. The other counts the frames the system still has free in that bin. The bins are the leaves of a binary tree. Every internal node holds the sum of its two children's used counts and the sum of their free counts.

A selection request walks from the root towards the leaves, one tree level per clock. At each node it steps into the child that has fewer pages of this address space and more free frames. The request carries a depth limit. The walk stops at that level and returns the index of a group of bins, so one instance serves caches that need fewer colors than the tree has leaves. Allocate, release and context-switch commands keep the counts current, and each update touches the whole leaf-to-root path in a single cycle.

Top module: `bb_frame_selector`

## Requirements
- R1: During and after a synchronous active-high reset, every used and free count is zero, `busy`, `res_done` and `res_fail` are low, and `res_group` is zero.
- R2: An allocate command (`cmd_op` = 2'b00) adds one to the used count and subtracts one from the free count of the named bin and of every ancestor of that bin. If the named bin's free count is zero, the command has no effect.
- R3: A release command (`cmd_op` = 2'b01) adds one to the free count of the named bin and of all its ancestors. If that bin's used count is non-zero, the command also subtracts one from those used counts. If that bin's used count is zero and the root's used plus free total has already reached 2^CNT_W-1, the command has no effect.
- R4: A context-switch command (`cmd_op` = 2'b10) clears every used count and leaves every free count unchanged. `cmd_op` = 2'b11 changes nothing.
- R5: Every internal node's used and free counts equal the sums of its two children's counts.
- R6: At each node the walk picks the child with the smaller used sum. On equal used sums it picks the child with the larger free sum. On equal free sums it picks the left (lower-index) child.
- R7: The walk never steps into a child whose free sum is zero while its sibling has free frames. When no bin has a free frame, `res_fail` is high with the result and `res_group` is 0.
- R8: For a depth D, `res_group` is the index of the chosen node among the 2^D nodes of level D, where level 0 is the root and level LEVELS holds the bins. A depth above LEVELS acts as LEVELS.
- R9: A request accepted in cycle T with effective depth D makes `res_done` high for exactly one cycle, T+D+2. `busy` is high from T+1 through T+D+1. The result and fail flag hold until the next result.
- R10: While `busy` is high, both `sel_req` and commands are ignored. When a command and a request arrive together while idle, the command takes effect first and the walk sees the updated counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 allocate, 01 release, 10 context switch, 11 none |
| cmd_bin | input | LEVELS | Bin the command applies to |
| sel_req | input | 1 | Start a selection walk |
| sel_depth | input | DEPTH_W | Tree level at which the walk stops |
| busy | output | 1 | A walk is in progress |
| res_done | output | 1 | One-cycle result strobe |
| res_fail | output | 1 | No bin had a free frame |
| res_group | output | LEVELS | Chosen group index at the requested level |

## Verification
The bench goes after four kinds of corner case. The first is the tie-break order. A design that compared free counts before used counts, or that preferred the right child on ties, would return the wrong bin when one half of the tree has more free frames and the other half has fewer pages of this address space. The second is the guards on empty bins and on the count limit. An allocate into an empty bin, or a release that wraps the counts, corrupts the path sums, and a later walk then lands in the wrong half of the tree. The third is commands and requests that arrive while a walk is running, which would shift the result if they were not dropped. The fourth is depths of zero, partial depths and depths above the leaf level, where a wrong clamp or group decode returns an index outside the requested level or delivers the done strobe in the wrong cycle.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic [1:0] {
        OP_ALLOC   = 2'b00,
        OP_RELEASE = 2'b01,
        OP_CTX     = 2'b10,
        OP_NONE    = 2'b11
    } bb_op_e;

    typedef struct packed {
        logic alloc;
        logic rel;
        logic ctx;
    } bb_upd_t;

    // Decide whether the walk steps into the right child.
    function automatic logic pick_right(input logic [31:0] used_l, input logic [31:0] free_l,
                                        input logic [31:0] used_r, input logic [31:0] free_r);
        logic take;
        if (free_r == 32'd0)      take = 1'b0;
        else if (free_l == 32'd0) take = 1'b1;
        else if (used_r != used_l) take = (used_r < used_l);
        else                      take = (free_r > free_l);
        return take;
    endfunction

endpackage

// File: rtl/bb_count_tree.sv
module bb_count_tree
    import bb_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int CNT_W  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  bb_upd_t             upd,
    input  logic [LEVELS-1:0]   bin,
    output logic [CNT_W-1:0]    used_q [0:(2<<LEVELS)-1],
    output logic [CNT_W-1:0]    free_q [0:(2<<LEVELS)-1]
);
    localparam int NB    = 1 << LEVELS;
    localparam int NODES = 2 * NB;
    localparam int NW    = LEVELS + 1;
    localparam logic [CNT_W:0] CNT_MAX = (CNT_W+1)'((1 << CNT_W) - 1);

    logic [NW-1:0]    leaf_idx;
    logic [CNT_W-1:0] leaf_used, leaf_free;
    logic [CNT_W:0]   root_total;
    logic             do_alloc, do_rel, rel_dec;

    always_comb begin
        leaf_idx   = {1'b1, bin};
        leaf_used  = used_q[leaf_idx];
        leaf_free  = free_q[leaf_idx];
        root_total = {1'b0, used_q[1]} + {1'b0, free_q[1]};
        do_alloc   = upd.alloc && (leaf_free != '0);
        rel_dec    = upd.rel && (leaf_used != '0);
        do_rel     = upd.rel && ((leaf_used != '0) || (root_total < CNT_MAX));
    end

    assign used_q[0] = '0;
    assign free_q[0] = '0;

    for (genvar n = 1; n < NODES; n++) begin : g_node
        localparam int LV = $clog2(n + 1) - 1;
        logic on_path;
        assign on_path = ((leaf_idx >> (LEVELS - LV)) == NW'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                used_q[n] <= '0;
                free_q[n] <= '0;
            end else if (upd.ctx) begin
                used_q[n] <= '0;
            end else if (on_path && do_alloc) begin
                used_q[n] <= used_q[n] + 1'b1;
                free_q[n] <= free_q[n] - 1'b1;
            end else if (on_path && do_rel) begin
                used_q[n] <= used_q[n] - CNT_W'(rel_dec);
                free_q[n] <= free_q[n] + 1'b1;
            end
        end

        if (n < NB) begin : g_sum_chk
            assert_used_sum_R5: assert property (@(posedge clk) disable iff (rst)
                ({1'b0, used_q[2*n]} + {1'b0, used_q[2*n+1]}) == {1'b0, used_q[n]});
            assert_free_sum_R5: assert property (@(posedge clk) disable iff (rst)
                ({1'b0, free_q[2*n]} + {1'b0, free_q[2*n+1]}) == {1'b0, free_q[n]});
        end
    end

    assert_ctx_clears_R4: assert property (@(posedge clk) disable iff (rst)
        upd.ctx |=> (used_q[1] == '0) && $stable(free_q[1]));
    assert_alloc_moves_R2: assert property (@(posedge clk) disable iff (rst)
        do_alloc |=> (free_q[1] == $past(free_q[1]) - 1'b1) && (used_q[1] == $past(used_q[1]) + 1'b1));
    assert_alloc_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (upd.alloc && !do_alloc) |=> $stable(used_q[1]) && $stable(free_q[1]));

endmodule

// File: rtl/bb_descent.sv
module bb_descent
    import bb_pkg::*;
#(
    parameter int LEVELS  = 3,
    parameter int CNT_W   = 4,
    parameter int DEPTH_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [DEPTH_W-1:0]  depth,
    input  logic [CNT_W-1:0]    used_q [0:(2<<LEVELS)-1],
    input  logic [CNT_W-1:0]    free_q [0:(2<<LEVELS)-1],
    output logic                busy,
    output logic                done,
    output logic                fail,
    output logic [LEVELS-1:0]   group
);
    localparam int NW = LEVELS + 1;
    localparam int LW = $clog2(LEVELS + 1);

    logic              busy_q, done_q, fail_q;
    logic [LEVELS-1:0] grp_q;
    logic [NW-1:0]     node_q;
    logic [LW-1:0]     lvl_q, tgt_q;
    logic [NW-1:0]     left_c, right_c;
    logic              go_right;
    logic [LW-1:0]     depth_eff;

    always_comb begin
        left_c    = {node_q[LEVELS-1:0], 1'b0};
        right_c   = {node_q[LEVELS-1:0], 1'b1};
        go_right  = pick_right(32'(used_q[left_c]), 32'(free_q[left_c]),
                               32'(used_q[right_c]), 32'(free_q[right_c]));
        depth_eff = (depth > DEPTH_W'(LEVELS)) ? LW'(LEVELS) : LW'(depth);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            grp_q  <= '0;
            node_q <= '0;
            lvl_q  <= '0;
            tgt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    node_q <= NW'(1);
                    lvl_q  <= '0;
                    tgt_q  <= depth_eff;
                end
            end else if (lvl_q == tgt_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                fail_q <= (free_q[node_q] == '0);
                grp_q  <= LEVELS'(node_q ^ (NW'(1) << lvl_q));
            end else begin
                node_q <= {node_q[LEVELS-1:0], go_right};
                lvl_q  <= lvl_q + 1'b1;
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign fail  = fail_q;
    assign group = grp_q;

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_q);
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    assert_pick_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
        (done_q && !fail_q) |-> (free_q[node_q] != '0));
    assert_fail_root_R7: assert property (@(posedge clk) disable iff (rst)
        (done_q && fail_q) |-> (free_q[1] == '0) && (grp_q == '0));

endmodule

// File: rtl/bb_frame_selector.sv
module bb_frame_selector
    import bb_pkg::*;
#(
    parameter int LEVELS  = 3,
    parameter int CNT_W   = 4,
    parameter int DEPTH_W = $clog2(LEVELS + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [LEVELS-1:0]   cmd_bin,
    input  logic                sel_req,
    input  logic [DEPTH_W-1:0]  sel_depth,
    output logic                busy,
    output logic                res_done,
    output logic                res_fail,
    output logic [LEVELS-1:0]   res_group
);
    localparam int NODES = 2 << LEVELS;

    bb_upd_t          upd;
    bb_op_e           op;
    logic             cmd_ok;
    logic [CNT_W-1:0] used_q [0:NODES-1];
    logic [CNT_W-1:0] free_q [0:NODES-1];

    always_comb begin
        op        = bb_op_e'(cmd_op);
        cmd_ok    = cmd_valid && !busy;
        upd.alloc = cmd_ok && (op == OP_ALLOC);
        upd.rel   = cmd_ok && (op == OP_RELEASE);
        upd.ctx   = cmd_ok && (op == OP_CTX);
    end

    bb_count_tree #(.LEVELS(LEVELS), .CNT_W(CNT_W)) u_tree (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .bin    (cmd_bin),
        .used_q (used_q),
        .free_q (free_q)
    );

    bb_descent #(.LEVELS(LEVELS), .CNT_W(CNT_W), .DEPTH_W(DEPTH_W)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (sel_req),
        .depth   (sel_depth),
        .used_q  (used_q),
        .free_q  (free_q),
        .busy    (busy),
        .done    (res_done),
        .fail    (res_fail),
        .group   (res_group)
    );

    assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(used_q[1]) && $stable(free_q[1]));

endmodule

// File: tb/tb_bb_frame_selector.sv
module tb_bb_frame_selector;
    localparam int L  = 3;
    localparam int NB = 8;
    localparam int MX = 15;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b11;
    logic [2:0] cmd_bin = '0;
    logic       sel_req = 1'b0;
    logic [2:0] sel_depth = '0;
    logic       busy, res_done, res_fail;
    logic [2:0] res_group;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    int um [NB];
    int fm [NB];

    always #5 clk = ~clk;

    bb_frame_selector dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bin(cmd_bin),
        .sel_req(sel_req), .sel_depth(sel_depth), .busy(busy), .res_done(res_done),
        .res_fail(res_fail), .res_group(res_group)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gsum(input bit want_used, input int d, input int g);
        int s = 0;
        for (int b = 0; b < NB; b++)
            if ((b >> (L - d)) == g) s += want_used ? um[b] : fm[b];
        return s;
    endfunction

    function automatic void mapply(input int op, input int b);
        int rt;
        rt = gsum(1, 0, 0) + gsum(0, 0, 0);
        case (op)
            0: if (fm[b] > 0) begin um[b]++; fm[b]--; end
            1: begin
                if (um[b] > 0) begin um[b]--; fm[b]++; end
                else if (rt < MX) fm[b]++;
            end
            2: for (int i = 0; i < NB; i++) um[i] = 0;
            default: ;
        endcase
    endfunction

    function automatic void msel(input int d, output int g, output bit f, output int de);
        int ul, fl, ur, fr;
        de = (d > L) ? L : d;
        g  = 0;
        f  = (gsum(0, 0, 0) == 0);
        for (int lv = 0; lv < de; lv++) begin
            ul = gsum(1, lv + 1, 2 * g);     fl = gsum(0, lv + 1, 2 * g);
            ur = gsum(1, lv + 1, 2 * g + 1); fr = gsum(0, lv + 1, 2 * g + 1);
            if (fr > 0 && (fl == 0 || ur < ul || (ur == ul && fr > fl))) g = 2 * g + 1;
            else g = 2 * g;
        end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NB; i++) begin um[i] = 0; fm[i] = 0; end
    endtask

    task automatic do_cmd(input int op, input int b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_bin = 3'(b);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11;
        mapply(op, b);
    endtask

    // Request a walk; optionally pair it with a command in the same cycle,
    // and optionally inject a command plus a second request mid-walk.
    task automatic do_sel(input int d, input string req, input int with_op, input int with_bin,
                          input bit poke);
        int eg, de, lat;
        bit ef, timing_ok;
        @(negedge clk);
        if (with_op >= 0) begin
            cmd_valid = 1'b1; cmd_op = 2'(with_op); cmd_bin = 3'(with_bin);
            mapply(with_op, with_bin);
        end
        msel(d, eg, ef, de);
        sel_req = 1'b1; sel_depth = 3'(d);
        lat = de + 2;
        timing_ok = 1;
        for (int k = 1; k < lat; k++) begin
            @(negedge clk);
            cmd_valid = 1'b0; cmd_op = 2'b11; sel_req = 1'b0;
            if (res_done || !busy) timing_ok = 0;
            if (poke && k == 1) begin
                cmd_valid = 1'b1; cmd_op = 2'b00; cmd_bin = 3'(eg << (L - de));
                sel_req = 1'b1; sel_depth = 3'd0;
            end
        end
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b11; sel_req = 1'b0;
        chk(timing_ok && res_done && !busy, "R9 done timing", int'(res_done), 1);
        chk(res_fail == ef, {req, " fail"}, int'(res_fail), int'(ef));
        chk(int'(res_group) == eg, {req, " group"}, int'(res_group), eg);
        @(negedge clk);
        chk(!res_done, "R9 single pulse", int'(res_done), 0);
        chk(int'(res_group) == eg, "R9 result held", int'(res_group), eg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int op, b, d;
        void'($urandom(32'd20061));
        for (int i = 0; i < NB; i++) begin um[i] = 0; fm[i] = 0; end
        @(negedge clk);
        chk(!busy && !res_done && !res_fail && res_group == 0, "R1 reset outputs",
            int'(busy) + int'(res_done), 0);
        do_reset();
        // R7: nothing free
        do_sel(3, "R7 empty fail", -1, 0, 0);
        // R6 tie -> left; then empty child skipped (R7)
        do_cmd(1, 2); do_cmd(1, 6);
        do_sel(3, "R6 tie lower", -1, 0, 0);
        do_cmd(0, 2);
        do_sel(3, "R7 skip empty", -1, 0, 0);
        // R6 used preference beats free, then R4 context switch
        do_reset();
        do_cmd(1, 1); do_cmd(1, 1); do_cmd(1, 1); do_cmd(1, 4);
        do_cmd(0, 1);
        do_sel(3, "R6 low used", -1, 0, 0);
        do_cmd(3, 0);
        do_sel(3, "R4 nop op", -1, 0, 0);
        do_cmd(2, 0);
        do_sel(3, "R4 ctx clear", -1, 0, 0);
        // R6 free tie-break
        do_reset();
        do_cmd(1, 0); do_cmd(1, 0); do_cmd(1, 7);
        do_sel(3, "R6 more free", -1, 0, 0);
        // R8 depths
        do_sel(0, "R8 depth0", -1, 0, 0);
        do_sel(1, "R8 depth1", -1, 0, 0);
        do_sel(7, "R8 depth clamp", -1, 0, 0);
        // R2 alloc into empty bin ignored
        do_reset();
        do_cmd(0, 5);
        do_cmd(1, 5); do_cmd(1, 5); do_cmd(1, 1);
        do_sel(3, "R2 empty alloc ignored", -1, 0, 0);
        // R3 release limit
        do_reset();
        for (int i = 0; i < 16; i++) do_cmd(1, 3);
        do_sel(3, "R3 release limit", -1, 0, 0);
        for (int i = 0; i < 15; i++) do_cmd(0, 3);
        do_sel(2, "R2 drained", -1, 0, 0);
        // R10 same-cycle command then walk, and mid-walk pokes ignored
        do_reset();
        do_cmd(1, 4);
        do_sel(3, "R10 same cycle", 1, 6, 0);
        do_sel(3, "R10 busy ignored", -1, 0, 1);
        do_sel(3, "R10 after busy", -1, 0, 0);
        // random phase
        do_reset();
        for (int it = 0; it < 400; it++) begin
            op = $urandom % 100;
            b  = $urandom % NB;
            if (op < 45) do_cmd(1, b);
            else if (op < 80) do_cmd(0, b);
            else if (op < 83) do_cmd(2, b);
            else if (op < 85) do_cmd(3, b);
            else begin
                d = $urandom % 5;
                if ($urandom % 4 == 0) do_sel(d, "R6 random paired", int'($urandom % 3), int'($urandom % NB), 0);
                else do_sel(d, "R6 random", -1, 0, 0);
            end
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule